// File: doc/BRIEF.md
# Software-Refilled Address Translation Cache

This block caches virtual-to-physical page translations in a small fully associative array of eight entries. A request presents a 32-bit virtual address, an access kind and a privilege flag. In the same cycle, the block compares the page number against every valid entry. On a permitted match, it returns the physical address. The page offset passes through unchanged.

When no entry matches, the block reports a miss and produces no address. Filling the entry is left to a handler outside the block. The handler writes the page number, frame number and permission bits through an insert port, then repeats the faulting access, which now matches. A match whose permissions forbid the access is reported as a protection fault and gives no address.

Entry choice follows a fixed order on insert:
- An existing entry with the same page number is rewritten in place.
- Otherwise the lowest-numbered free entry is used.
- Otherwise a round-robin pointer picks the entry to replace.

A flush input empties the whole array in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, no entry is valid, and every request reports a miss.
- R2: The page number is vaddr[31:12]. A request matches when a valid entry holds that page number. The lookup is combinational and resolves in the same cycle as the request.
- R3: On a permitted match, xlate_ok is 1 and paddr = {pfn, vaddr[11:0]}. In every other case, paddr is 0.
- R4: Permission bits are [0] read, [1] write, [2] execute, [3] user. Access kinds are 0 load (needs read), 1 store (needs write), 2 fetch (needs execute) and 3 reserved (always denied). A user-mode request also needs bit 3. A denied match gives hit=1, prot_fault=1, xlate_ok=0.
- R5: A valid request with no matching entry gives miss=1, with hit, prot_fault and xlate_ok all 0.
- R6: While req_valid is 0, hit, miss, prot_fault and xlate_ok are all 0.
- R7: An insert takes effect at the next clock edge. After that edge, the same virtual address matches with the inserted frame number and permissions.
- R8: While any entry is invalid, an insert of a new page number evicts no valid translation. It fills the lowest-numbered invalid entry.
- R9: When all entries are valid, a new page number replaces the entry named by a round-robin pointer. The pointer starts at entry 0 after reset or flush and advances by one, wrapping, on each such replacement.
- R10: An insert whose page number is already cached overwrites that entry in place. It evicts nothing else and leaves the round-robin pointer unchanged.
- R11: A flush clears every entry in one cycle. It takes priority over an insert in the same cycle, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| req_user | input | 1 | Request issued in user mode |
| hit | output | 1 | A valid entry matched the page number |
| miss | output | 1 | No valid entry matched |
| prot_fault | output | 1 | Matched, but the access is not permitted |
| xlate_ok | output | 1 | Permitted match; paddr is valid |
| paddr | output | 32 | Translated physical address |
| ins_en | input | 1 | Write a translation |
| ins_vpn | input | 20 | Page number to install |
| ins_pfn | input | 20 | Frame number to install |
| ins_prot | input | 4 | Permission bits to install |

## Verification
The assertions assume that software never places two valid entries with the same page number in the array. The no-multiple-match check relies on this. The insert path upholds it by rewriting a matching entry, and the bench exercises this by reinserting cached page numbers with new permissions.

The assertions also assume that every input is driven to a known value from reset onward. The bench drives each input to a defined level before reset is released, and changes inputs only on falling edges. Lookups are sampled shortly after those changes, while the clock is low.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef struct packed {
        logic user;
        logic exec;
        logic write;
        logic read;
    } prot_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    function automatic logic access_ok(prot_t p, acc_e a, logic user_mode);
        logic ok;
        case (a)
            ACC_LOAD:  ok = p.read;
            ACC_STORE: ok = p.write;
            ACC_FETCH: ok = p.exec;
            default:   ok = 1'b0;
        endcase
        if (user_mode && !p.user) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  prot_t              wr_prot,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic [ENTRIES-1:0] valid,
    output logic [ENTRIES-1:0] lk_match,
    output logic [ENTRIES-1:0] wr_match,
    output logic [PFN_W-1:0]   rd_pfn,
    output prot_t              rd_prot
);

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    prot_t              prot_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst || flush)   valid_q <= '0;
        else if (wr_en)     valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            vpn_q[wr_idx]  <= wr_vpn;
            pfn_q[wr_idx]  <= wr_pfn;
            prot_q[wr_idx] <= wr_prot;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
        assign wr_match[g] = valid_q[g] && (vpn_q[g] == wr_vpn);
    end

    always_comb begin
        rd_pfn  = '0;
        rd_prot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            rd_pfn  = rd_pfn  | ({PFN_W{lk_match[i]}} & pfn_q[i]);
            rd_prot = rd_prot | ({4{lk_match[i]}} & prot_q[i]);
        end
    end

    assign valid = valid_q;

    // R10
    no_multihit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    // R7
    insert_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] wr_match,
    output logic [IDX_W-1:0]   wr_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] match_idx, free_idx;
    logic             any_match, any_free, use_rr;

    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        any_match = 1'b0;
        any_free  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_match[i] && !any_match) begin
                match_idx = IDX_W'(i);
                any_match = 1'b1;
            end
            if (!valid[i] && !any_free) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign use_rr = !any_match && !any_free;
    assign wr_idx = any_match ? match_idx : (any_free ? free_idx : rr_q);

    always_ff @(posedge clk) begin
        if (rst || flush)          rr_q <= '0;
        else if (wr_en && use_rr)  rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end

    // R8
    free_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (!(&valid) && !(|wr_match)) |-> !valid[wr_idx]);

    // R9
    rr_range_chk: assert property (@(posedge clk) disable iff (rst)
        rr_q <= LAST);

    // R10
    rr_hold_chk: assert property (@(posedge clk) disable iff (rst || flush)
        (wr_en && (|wr_match)) |=> $stable(rr_q));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PFN_W  = PA_W - OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic             req_user,
    output logic             hit,
    output logic             miss,
    output logic             prot_fault,
    output logic             xlate_ok,
    output logic [PA_W-1:0]  paddr,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PFN_W-1:0] ins_pfn,
    input  logic [3:0]       ins_prot
);

    localparam logic [VA_W-1:0] VPN_MASK = {{VPN_W{1'b1}}, {OFF_W{1'b0}}};

    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] valid, lk_match, wr_match;
    logic [PFN_W-1:0]   rd_pfn;
    prot_t              rd_prot;
    logic [IDX_W-1:0]   wr_idx;
    logic               wr_en, permit;

    assign lk_vpn = VPN_W'((req_vaddr & VPN_MASK) >> OFF_W);
    assign wr_en  = ins_en && !flush;

    tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_vpn   (ins_vpn),
        .wr_pfn   (ins_pfn),
        .wr_prot  (prot_t'(ins_prot)),
        .lk_vpn   (lk_vpn),
        .valid    (valid),
        .lk_match (lk_match),
        .wr_match (wr_match),
        .rd_pfn   (rd_pfn),
        .rd_prot  (rd_prot)
    );

    tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (wr_en),
        .valid    (valid),
        .wr_match (wr_match),
        .wr_idx   (wr_idx)
    );

    assign permit     = access_ok(rd_prot, acc_e'(req_acc), req_user);
    assign hit        = req_valid && (|lk_match);
    assign miss       = req_valid && !(|lk_match);
    assign prot_fault = hit && !permit;
    assign xlate_ok   = hit && permit;
    assign paddr      = xlate_ok ? {rd_pfn, req_vaddr[OFF_W-1:0]} : '0;

    // R5
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({miss, prot_fault, xlate_ok}));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !(hit || miss || prot_fault || xlate_ok));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        xlate_ok |-> (paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]));

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        $past(rst) |-> (valid == '0));

endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        hit, miss, prot_fault, xlate_ok;
    logic [31:0] paddr;
    logic        ins_en = 1'b0;
    logic [19:0] ins_vpn = '0;
    logic [19:0] ins_pfn = '0;
    logic [3:0]  ins_prot = '0;

    int compared = 0;
    int mismatched = 0;

    logic        m_valid [8];
    logic [19:0] m_vpn   [8];
    logic [19:0] m_pfn   [8];
    logic [3:0]  m_prot  [8];
    int          m_rr;

    always #2 clk = ~clk;

    tlb_xlate i_tlb_xlate (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
        .hit(hit), .miss(miss), .prot_fault(prot_fault), .xlate_ok(xlate_ok), .paddr(paddr),
        .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_pfn(ins_pfn), .ins_prot(ins_prot)
    );

    task automatic model_clear();
        for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
        m_rr = 0;
    endtask

    task automatic model_insert(input logic [19:0] v, input logic [19:0] p, input logic [3:0] pr);
        int slot = -1;
        for (int i = 0; i < 8; i++) if (slot < 0 && m_valid[i] && m_vpn[i] == v) slot = i;
        if (slot < 0) for (int i = 0; i < 8; i++) if (slot < 0 && !m_valid[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % 8;
        end
        m_valid[slot] = 1'b1;
        m_vpn[slot]   = v;
        m_pfn[slot]   = p;
        m_prot[slot]  = pr;
    endtask

    function automatic logic allowed(input logic [3:0] pr, input logic [1:0] a, input logic u);
        logic ok;
        case (a)
            2'd0: ok = pr[0];
            2'd1: ok = pr[1];
            2'd2: ok = pr[2];
            default: ok = 1'b0;
        endcase
        if (u && !pr[3]) ok = 1'b0;
        return ok;
    endfunction

    task automatic do_insert(input logic [19:0] v, input logic [19:0] p, input logic [3:0] pr,
                             input logic with_flush);
        @(negedge clk);
        ins_en = 1'b1; ins_vpn = v; ins_pfn = p; ins_prot = pr; flush = with_flush;
        @(negedge clk);
        ins_en = 1'b0; flush = 1'b0;
        if (with_flush) model_clear();
        else model_insert(v, p, pr);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_clear();
    endtask

    task automatic check_lookup(input logic rv, input logic [31:0] va, input logic [1:0] a,
                                input logic u, input string tag);
        logic e_hit, e_miss, e_pf, e_ok;
        logic [31:0] e_pa;
        int slot = -1;
        @(negedge clk);
        req_valid = rv; req_vaddr = va; req_acc = a; req_user = u;
        #1;
        for (int i = 0; i < 8; i++) if (m_valid[i] && m_vpn[i] == va[31:12]) slot = i;
        e_hit  = rv && slot >= 0;
        e_miss = rv && slot < 0;
        e_ok   = e_hit && allowed(m_prot[slot < 0 ? 0 : slot], a, u);
        e_pf   = e_hit && !e_ok;
        e_pa   = e_ok ? {m_pfn[slot], va[11:0]} : 32'h0;
        compared++;
        if ({hit, miss, prot_fault, xlate_ok} !== {e_hit, e_miss, e_pf, e_ok} || paddr !== e_pa) begin
            mismatched++;
            $display("FAIL %s va=%h acc=%0d user=%0d actual hit/miss/pf/ok=%b%b%b%b pa=%h expected=%b%b%b%b pa=%h",
                     tag, va, a, u, hit, miss, prot_fault, xlate_ok, paddr,
                     e_hit, e_miss, e_pf, e_ok, e_pa);
        end
        req_valid = 1'b0;
    endtask

    task automatic sweep_cached(input string tag);
        for (int i = 0; i < 8; i++)
            if (m_valid[i]) check_lookup(1'b1, {m_vpn[i], 12'(i * 397 + 5)}, 2'd0, 1'b0, tag);
    endtask

    initial begin
        #800000;
        mismatched++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        check_lookup(1'b1, 32'h0000_0000, 2'd0, 1'b0, "R1");
        check_lookup(1'b1, 32'hFFFF_FFFF, 2'd2, 1'b1, "R1");
        // R6: idle request
        check_lookup(1'b0, 32'h1234_5678, 2'd0, 1'b0, "R6");

        // R7 R8: fill all entries, no eviction while free
        for (int i = 0; i < 8; i++) begin
            do_insert(20'(32'h100 + i * 37), 20'(32'hA000 + i * 3), 4'hF, 1'b0);
            check_lookup(1'b1, {20'(32'h100 + i * 37), 12'hABC}, 2'd1, 1'b1, "R7");
            sweep_cached("R8");
        end

        // R2 R3: every entry, every offset pattern, every access kind
        for (int i = 0; i < 8; i++)
            for (int a = 0; a < 4; a++)
                check_lookup(1'b1, {m_vpn[i], 12'(a * 1111 + i)}, 2'(a), 1'(a & 1), "R3");
        // R5: neighbouring page numbers miss
        check_lookup(1'b1, {20'h101, 12'h000}, 2'd0, 1'b0, "R5");
        check_lookup(1'b1, {20'h0FF, 12'hFFF}, 2'd0, 1'b0, "R5");
        // R2: vaddr upper bits matter
        check_lookup(1'b1, {20'h100 ^ 20'h80000, 12'h010}, 2'd0, 1'b0, "R2");

        // R4 R10: rewrite entry permissions in place, full sweep
        for (int p = 0; p < 16; p++) begin
            do_insert(m_vpn[3], 20'(32'hB000 + p), 4'(p), 1'b0);
            for (int a = 0; a < 4; a++)
                for (int u = 0; u < 2; u++)
                    check_lookup(1'b1, {m_vpn[3], 12'h3C5}, 2'(a), 1'(u), "R4");
        end
        sweep_cached("R10");

        // R9: replacements walk entries 0,1,2
        for (int k = 0; k < 3; k++) begin
            do_insert(20'(32'h9000 + k), 20'(32'hC000 + k), 4'h7, 1'b0);
            check_lookup(1'b1, {20'(32'h100 + k * 37), 12'h0}, 2'd0, 1'b0, "R9");
            sweep_cached("R9");
        end
        // R10: reinsert of cached page does not move pointer
        do_insert(20'h9001, 20'hD001, 4'h1, 1'b0);
        do_insert(20'h9100, 20'hD100, 4'h1, 1'b0);
        check_lookup(1'b1, {20'(32'h100 + 3 * 37), 12'h0}, 2'd0, 1'b0, "R10");
        sweep_cached("R10");

        // R11: flush wins over simultaneous insert
        do_insert(20'h7777, 20'h1111, 4'hF, 1'b1);
        check_lookup(1'b1, {20'h7777, 12'h0}, 2'd0, 1'b0, "R11");
        check_lookup(1'b1, {20'h9000, 12'h0}, 2'd0, 1'b0, "R11");
        // R11 R9: pointer restarts at entry 0 after flush
        for (int i = 0; i < 9; i++) do_insert(20'(32'h4000 + i), 20'(32'h5000 + i), 4'h1, 1'b0);
        check_lookup(1'b1, {20'h4000, 12'h0}, 2'd0, 1'b0, "R9");
        sweep_cached("R11");
        do_flush();
        check_lookup(1'b1, {20'h4001, 12'h0}, 2'd0, 1'b0, "R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule